// File: doc/BRIEF.md
# Operate Micro-Instruction Executor

This block carries out the register-only "operate" instruction of a 12-bit accumulator machine that has a single carry/link flag. The instruction word, the present accumulator, the link and a console switch register come in together with a valid strobe. One clock later the block returns the new accumulator, the new link, a request to skip the following instruction, and a request to halt. The surrounding sequencer applies these results, advancing the program counter by one more word when a skip is requested.

The nine low instruction bits are independent micro-operation selects. Any combination of them may be set in a single word, and the block applies the selected steps in a fixed order. Bit 8 picks one of two groups. The first group clears, complements, increments and rotates the accumulator and the link. The second group tests conditions for a skip, clears the accumulator, merges in the switch register and raises a halt request. Words with any other opcode are left to other units.

Top module: `opr_unit`

## Requirements
- R1: A word is accepted only when `valid_i` is high and bits 11:9 equal 3'b111. `valid_o` then pulses high for exactly one cycle, one clock later. Any other word, or a low `valid_i`, gives no `valid_o`, and `acc_o` and `link_o` keep their earlier values.
- R2: While `rst_ni` is low, `valid_o`, `acc_o`, `link_o`, `skip_o` and `halt_o` are all zero.
- R3: Group 1 (bit 8 = 0) applies its clears before its complements. Bit 7 zeroes AC and bit 6 zeroes link. Then bit 5 inverts AC and bit 4 inverts link. Setting a clear and the matching complement together therefore gives all ones.
- R4: In group 1, bit 0 adds one to AC after the complements. A carry out of the top AC bit inverts the link. Bits 7 and 0 together give AC = 1.
- R5: In group 1, the rotate is applied last, to the 13-bit value {link, AC}. Bit 3 rotates right and bit 2 rotates left. Bit 1 makes the rotate two places instead of one. On a right rotate, link receives AC[0] and AC[11] receives the old link.
- R6: In group 1, if bits 3 and 2 are both set, no rotate takes place. Bit 1 on its own changes nothing.
- R7: A group 1 word never raises `skip_o` or `halt_o`.
- R8: In group 2 (bit 8 = 1), three skip conditions can be selected. Bit 6 tests for a negative AC (AC[11] = 1), bit 5 for a zero AC, and bit 4 for a link of 1. All three are tested on the incoming AC and link. With bit 3 = 0, a skip is raised when any selected condition holds.
- R9: In group 2 with bit 3 = 1, a skip is raised only when none of the selected conditions holds. If no condition is selected, the skip is unconditional.
- R10: In group 2, bit 7 zeroes AC after the skip test. Bit 2 then ORs `sw_i` into AC. The link leaves the block unchanged.
- R11: In group 2, bit 1 raises `halt_o`. Bit 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operands present this cycle |
| instr_i | input | 12 | Instruction word |
| acc_i | input | DATA_W | Incoming accumulator |
| link_i | input | 1 | Incoming link flag |
| sw_i | input | DATA_W | Console switch register |
| valid_o | output | 1 | Result strobe, one cycle after an accepted word |
| acc_o | output | DATA_W | Resulting accumulator |
| link_o | output | 1 | Resulting link flag |
| skip_o | output | 1 | Skip-next-instruction request |
| halt_o | output | 1 | Halt request |

## Verification
The assertions check the following on every cycle:
- the strobe timing and hold behaviour;
- that group 1 never skips or halts;
- that group 2 passes the link through unchanged;
- the halt bit;
- the unconditional skip;
- the cleared accumulator when no switch merge is selected.

The ordering between micro-operations shows only in the data values, so only the bench scenarios can demonstrate it. Examples are clear-then-complement, increment carry into the link, rotate through the link, and skip tests on the pre-clear AC. The bench sweeps all 512 low-bit patterns over several operand patterns and compares each result with values it computes step by step.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int unsigned INSTR_W = 12;
  localparam logic [2:0]  OPC_OPERATE = 3'b111;

  // instruction field positions (shared by both groups unless noted)
  localparam int unsigned B_GRP    = 8;
  localparam int unsigned B_CLRA   = 7;
  localparam int unsigned B1_CLRL  = 6;
  localparam int unsigned B1_CPLA  = 5;
  localparam int unsigned B1_CPLL  = 4;
  localparam int unsigned B1_ROTR  = 3;
  localparam int unsigned B1_ROTL  = 2;
  localparam int unsigned B1_TWO   = 1;
  localparam int unsigned B1_INC   = 0;
  localparam int unsigned B2_NEG   = 6;
  localparam int unsigned B2_ZERO  = 5;
  localparam int unsigned B2_LINK  = 4;
  localparam int unsigned B2_SENSE = 3;
  localparam int unsigned B2_OSR   = 2;
  localparam int unsigned B2_HALT  = 1;

  typedef struct packed {
    logic clr_acc;
    logic clr_link;
    logic cpl_acc;
    logic cpl_link;
    logic rot_r;
    logic rot_l;
    logic rot_two;
    logic inc;
  } g1_ctl_t;

  typedef struct packed {
    logic tst_neg;
    logic tst_zero;
    logic tst_link;
    logic inv_sense;
    logic clr_acc;
    logic or_sw;
    logic halt;
  } g2_ctl_t;
endpackage

// File: rtl/opr_grp1.sv
module opr_grp1
  import opr_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  g1_ctl_t           ctl_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              link_o
);
  localparam int unsigned W13 = DATA_W + 1;

  logic [DATA_W-1:0] a_clr, a_cpl;
  logic              l_clr, l_cpl;
  logic [DATA_W:0]   sum;
  logic [W13-1:0]    word, rot_r1, rot_r2, rot_l1, rot_l2, rot;
  logic              do_r, do_l;

  // level 1: clears, level 2: complements
  assign a_clr = ctl_i.clr_acc  ? '0 : acc_i;
  assign l_clr = ctl_i.clr_link ? 1'b0 : link_i;
  assign a_cpl = ctl_i.cpl_acc  ? ~a_clr : a_clr;
  assign l_cpl = ctl_i.cpl_link ? ~l_clr : l_clr;

  // level 3: increment, carry flips link
  assign sum  = {1'b0, a_cpl} + {{DATA_W{1'b0}}, ctl_i.inc};
  assign word = {l_cpl ^ sum[DATA_W], sum[DATA_W-1:0]};

  // level 4: rotate through link
  assign rot_r1 = {word[0], word[W13-1:1]};
  assign rot_r2 = {word[1:0], word[W13-1:2]};
  assign rot_l1 = {word[W13-2:0], word[W13-1]};
  assign rot_l2 = {word[W13-3:0], word[W13-1:W13-2]};
  assign do_r   = ctl_i.rot_r & ~ctl_i.rot_l;
  assign do_l   = ctl_i.rot_l & ~ctl_i.rot_r;

  always_comb begin
    rot = word;
    if (do_r)      rot = ctl_i.rot_two ? rot_r2 : rot_r1;
    else if (do_l) rot = ctl_i.rot_two ? rot_l2 : rot_l1;
  end

  assign acc_o  = rot[DATA_W-1:0];
  assign link_o = rot[DATA_W];

  always_comb begin
    if (!(ctl_i.rot_r ^ ctl_i.rot_l))
      a_r6_no_rot: assert ({link_o, acc_o} == word);
  end
endmodule

// File: rtl/opr_grp2.sv
module opr_grp2
  import opr_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  g2_ctl_t           ctl_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              skip_o,
  output logic              halt_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic hit_neg, hit_zero, hit_link, hit_any;
  logic [DATA_W-1:0] a_clr;

  // level 1: tests on incoming operands
  assign hit_neg  = ctl_i.tst_neg  & acc_i[MSB];
  assign hit_zero = ctl_i.tst_zero & ~(|acc_i);
  assign hit_link = ctl_i.tst_link & link_i;
  assign hit_any  = hit_neg | hit_zero | hit_link;
  assign skip_o   = ctl_i.inv_sense ? ~hit_any : hit_any;

  // level 2: clear, level 3: switch merge and halt
  assign a_clr  = ctl_i.clr_acc ? '0 : acc_i;
  assign acc_o  = ctl_i.or_sw ? (a_clr | sw_i) : a_clr;
  assign halt_o = ctl_i.halt;
endmodule

// File: rtl/opr_unit.sv
module opr_unit
  import opr_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [11:0]       instr_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              link_o,
  output logic              skip_o,
  output logic              halt_o
);
  localparam int unsigned OPC_LO = INSTR_W - 3;

  logic              sel, grp2;
  g1_ctl_t           g1_ctl;
  g2_ctl_t           g2_ctl;
  logic [DATA_W-1:0] g1_acc, g2_acc, acc_nx;
  logic              g1_link, g2_skip, g2_halt, link_nx;

  assign sel  = valid_i && (instr_i[INSTR_W-1:OPC_LO] == OPC_OPERATE);
  assign grp2 = instr_i[B_GRP];

  always_comb begin
    g1_ctl.clr_acc  = instr_i[B_CLRA];
    g1_ctl.clr_link = instr_i[B1_CLRL];
    g1_ctl.cpl_acc  = instr_i[B1_CPLA];
    g1_ctl.cpl_link = instr_i[B1_CPLL];
    g1_ctl.rot_r    = instr_i[B1_ROTR];
    g1_ctl.rot_l    = instr_i[B1_ROTL];
    g1_ctl.rot_two  = instr_i[B1_TWO];
    g1_ctl.inc      = instr_i[B1_INC];
    g2_ctl.tst_neg   = instr_i[B2_NEG];
    g2_ctl.tst_zero  = instr_i[B2_ZERO];
    g2_ctl.tst_link  = instr_i[B2_LINK];
    g2_ctl.inv_sense = instr_i[B2_SENSE];
    g2_ctl.clr_acc   = instr_i[B_CLRA];
    g2_ctl.or_sw     = instr_i[B2_OSR];
    g2_ctl.halt      = instr_i[B2_HALT];
  end

  opr_grp1 #(.DATA_W(DATA_W)) u_grp1 (
    .ctl_i  (g1_ctl),
    .acc_i  (acc_i),
    .link_i (link_i),
    .acc_o  (g1_acc),
    .link_o (g1_link)
  );

  opr_grp2 #(.DATA_W(DATA_W)) u_grp2 (
    .ctl_i  (g2_ctl),
    .acc_i  (acc_i),
    .link_i (link_i),
    .sw_i   (sw_i),
    .acc_o  (g2_acc),
    .skip_o (g2_skip),
    .halt_o (g2_halt)
  );

  assign acc_nx  = grp2 ? g2_acc : g1_acc;
  assign link_nx = grp2 ? link_i : g1_link;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      acc_o   <= '0;
      link_o  <= 1'b0;
      skip_o  <= 1'b0;
      halt_o  <= 1'b0;
    end else begin
      valid_o <= sel;
      if (sel) begin
        acc_o  <= acc_nx;
        link_o <= link_nx;
        skip_o <= grp2 & g2_skip;
        halt_o <= grp2 & g2_halt;
      end
    end
  end

  a_r1_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel |=> valid_o);
  a_r1_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |=> !valid_o);
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |=> ($stable(acc_o) && $stable(link_o)));
  a_r7_g1_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !instr_i[B_GRP]) |=> (!skip_o && !halt_o));
  a_r10_link_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && instr_i[B_GRP]) |=> (link_o == $past(link_i)));
  a_r10_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && instr_i[B_GRP] && instr_i[B_CLRA] && !instr_i[B2_OSR]) |=> (acc_o == '0));
  a_r9_open_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && instr_i[B_GRP] && instr_i[B2_SENSE] && (instr_i[6:4] == 3'b000)) |=> skip_o);
  a_r11_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && instr_i[B_GRP]) |=> (halt_o == $past(instr_i[B2_HALT])));
endmodule

// File: tb/opr_unit_tb.sv
module opr_unit_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [11:0] instr_i = '0;
  logic [11:0] acc_i = '0;
  logic        link_i = 1'b0;
  logic [11:0] sw_i = '0;
  logic        valid_o, link_o, skip_o, halt_o;
  logic [11:0] acc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  opr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .acc_i(acc_i), .link_i(link_i), .sw_i(sw_i), .valid_o(valid_o),
    .acc_o(acc_o), .link_o(link_o), .skip_o(skip_o), .halt_o(halt_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %o expected %o", tag, act, exp);
    end
  endtask

  // drive one word, return after result is registered (sampled at negedge)
  task automatic run(input logic v, input logic [11:0] ins, input logic [11:0] a,
                     input logic l, input logic [11:0] s);
    @(negedge clk);
    valid_i = v; instr_i = ins; acc_i = a; link_i = l; sw_i = s;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // reference: {halt, skip, link, acc}
  function automatic logic [14:0] model(input logic [11:0] ins, input logic [11:0] a,
                                        input logic l, input logic [11:0] s);
    logic [12:0] v;
    logic [25:0] dbl;
    logic cond, sk;
    int n;
    if (!ins[8]) begin
      if (ins[7]) a = 12'o0;
      if (ins[6]) l = 1'b0;
      if (ins[5]) a = ~a;
      if (ins[4]) l = ~l;
      v = {l, a};
      if (ins[0]) v = v + 13'd1;
      n = ins[1] ? 2 : 1;
      dbl = {v, v};
      if (ins[3] && !ins[2]) v = dbl[12+n -: 13] ;
      else if (ins[2] && !ins[3]) v = dbl[25-n -: 13];
      return {1'b0, 1'b0, v};
    end
    cond = (ins[6] && a[11]) || (ins[5] && a == 12'o0) || (ins[4] && l);
    sk = ins[3] ? !cond : cond;
    if (ins[7]) a = 12'o0;
    if (ins[2]) a = a | s;
    return {ins[1], sk, l, a};
  endfunction

  function automatic string tag_acc(input logic [11:0] ins);
    if (ins[8]) return "R10";
    if (ins[3] && ins[2]) return "R6";
    if (ins[3] || ins[2]) return "R5";
    if (ins[0]) return "R4";
    return "R3";
  endfunction

  task automatic run_chk(input logic [11:0] ins, input logic [11:0] a,
                         input logic l, input logic [11:0] s);
    logic [14:0] e;
    e = model(ins, a, l, s);
    run(1'b1, ins, a, l, s);
    chk("R1 strobe", {15'd0, valid_o}, 16'd1);
    chk(tag_acc(ins), {4'd0, acc_o}, {4'd0, e[11:0]});
    chk(tag_acc(ins), {15'd0, link_o}, {15'd0, e[12]});
    chk(ins[8] ? (ins[3] ? "R9" : "R8") : "R7", {15'd0, skip_o}, {15'd0, e[13]});
    chk(ins[8] ? "R11" : "R7", {15'd0, halt_o}, {15'd0, e[14]});
  endtask

  initial begin
    #(CLK_P*150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] pats [7];
    logic [11:0] a0, a1;
    pats = '{12'o0000, 12'o7777, 12'o4000, 12'o0001, 12'o2525, 12'o5252, 12'o3777};

    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 valid", {15'd0, valid_o}, 16'd0);
    chk("R2 acc", {4'd0, acc_o}, 16'd0);
    chk("R2 flags", {13'd0, link_o, skip_o, halt_o}, 16'd0);
    rst_ni = 1'b1;

    // R1: accepted word, then non-operate opcode and idle valid hold outputs
    run(1'b1, 12'o7200, 12'o1111, 1'b1, 12'o0);
    chk("R1 accept", {15'd0, valid_o}, 16'd1);
    run(1'b1, 12'o1357, 12'o4444, 1'b0, 12'o0);
    chk("R1 other opcode valid", {15'd0, valid_o}, 16'd0);
    chk("R1 other opcode acc", {4'd0, acc_o}, 16'd0);
    chk("R1 other opcode link", {15'd0, link_o}, 16'd1);
    run(1'b0, 12'o7240, 12'o4444, 1'b0, 12'o0);
    chk("R1 idle valid", {15'd0, valid_o}, 16'd0);
    chk("R1 idle acc", {4'd0, acc_o}, 16'd0);

    // R3 clear before complement
    run(1'b1, 12'o7360, 12'o1234, 1'b0, 12'o0);
    chk("R3 acc", {4'd0, acc_o}, 16'o7777);
    chk("R3 link", {15'd0, link_o}, 16'd1);
    // R4 increment carry flips link; clear+inc
    run(1'b1, 12'o7001, 12'o7777, 1'b0, 12'o0);
    chk("R4 wrap acc", {4'd0, acc_o}, 16'd0);
    chk("R4 carry link", {15'd0, link_o}, 16'd1);
    run(1'b1, 12'o7201, 12'o5555, 1'b0, 12'o0);
    chk("R4 clear inc", {4'd0, acc_o}, 16'd1);
    // R5 rotates through link
    run(1'b1, 12'o7010, 12'o0001, 1'b0, 12'o0);
    chk("R5 right acc", {4'd0, acc_o}, 16'd0);
    chk("R5 right link", {15'd0, link_o}, 16'd1);
    run(1'b1, 12'o7006, 12'o4000, 1'b0, 12'o0);
    chk("R5 left two acc", {4'd0, acc_o}, 16'o0001);
    chk("R5 left two link", {15'd0, link_o}, 16'd0);
    // R6 conflicting rotates / lone two-place bit
    run(1'b1, 12'o7014, 12'o2525, 1'b1, 12'o0);
    chk("R6 both rot", {3'd0, link_o, acc_o}, {4'd1, 12'o2525});
    run(1'b1, 12'o7002, 12'o2525, 1'b0, 12'o0);
    chk("R6 lone two", {3'd0, link_o, acc_o}, {4'd0, 12'o2525});
    // R7 group 1 no skip/halt
    run(1'b1, 12'o7377, 12'o0000, 1'b1, 12'o0);
    chk("R7 quiet", {14'd0, skip_o, halt_o}, 16'd0);
    // R8 skip tests on incoming values
    run(1'b1, 12'o7500, 12'o4000, 1'b0, 12'o0);
    chk("R8 neg", {15'd0, skip_o}, 16'd1);
    run(1'b1, 12'o7500, 12'o3777, 1'b0, 12'o0);
    chk("R8 not neg", {15'd0, skip_o}, 16'd0);
    run(1'b1, 12'o7640, 12'o0005, 1'b0, 12'o0);
    chk("R8 zero before clear", {15'd0, skip_o}, 16'd0);
    chk("R8 cleared acc", {4'd0, acc_o}, 16'd0);
    // R9 inverted sense
    run(1'b1, 12'o7410, 12'o1234, 1'b0, 12'o0);
    chk("R9 unconditional", {15'd0, skip_o}, 16'd1);
    run(1'b1, 12'o7450, 12'o0000, 1'b0, 12'o0);
    chk("R9 zero suppresses", {15'd0, skip_o}, 16'd0);
    // R10 clear then switch merge, link kept
    run(1'b1, 12'o7604, 12'o7777, 1'b1, 12'o1357);
    chk("R10 acc", {4'd0, acc_o}, 16'o1357);
    chk("R10 link", {15'd0, link_o}, 16'd1);
    // R11 halt, bit 0 ignored
    run(1'b1, 12'o7402, 12'o0123, 1'b0, 12'o0);
    chk("R11 halt", {15'd0, halt_o}, 16'd1);
    a0 = acc_o;
    run(1'b1, 12'o7403, 12'o0123, 1'b0, 12'o0);
    chk("R11 bit0 ignored", {3'd0, halt_o, acc_o}, {4'd1, a0});
    run(1'b1, 12'o7765, 12'o4321, 1'b1, 12'o0707);
    a1 = acc_o;
    chk("R11 bit0 ignored sk", {15'd0, skip_o}, {15'd0, model(12'o7765, 12'o4321, 1'b1, 12'o0707)[13]});
    run(1'b1, 12'o7764, 12'o4321, 1'b1, 12'o0707);
    chk("R11 bit0 ignored acc", {4'd0, acc_o}, {4'd0, a1});

    // sweep of all micro-op patterns
    for (int p = 0; p < 512; p++)
      for (int d = 0; d < 7; d++)
        for (int l = 0; l < 2; l++)
          run_chk({3'b111, p[8:0]}, pats[d], l[0], pats[d] ^ 12'o1234);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule